// File: doc/BRIEF.md
# Late-Write Burst Synchronous SRAM

This block is a single-port synchronous word memory. It is built so that reads and writes can be issued on consecutive clocks in any order with no idle bus cycle between them. A read is flow-through: the word at the registered address is presented on the output during the clock period that follows the command edge. A write is late: the command, address and byte enables are registered on one edge, and the matching data is taken from the data-in bus on the next enabled edge. Write latency therefore equals read latency, and the shared external bus never has to turn around in mid-cycle.

A new cycle begins when the load control is low. A read or write begins only when all three chip selects are in their active state. When the load control is high, the cycle continues the current burst. It reuses the operation chosen at the start of the burst, and it takes its address from a separate burst address generator through a dedicated input. The clock enable can freeze the whole pipeline for any number of cycles. The output enable gates the data drivers without waiting for a clock edge.

A written word waits in a one-entry staging register and goes into the array on the following enabled edge. A read of that same word returns the staged bytes through a forwarding path, so it always sees the newest data.

Top module: `lw_burst_sram`

## Requirements
- R1: After reset the pipeline holds a deselect operation, the continue-burst operation is deselect, and `dout_oe` is 0.
- R2: A begin cycle (`ld_n`=0) with `ce0_n`=0, `ce1`=1, `ce2_n`=0 and `rd_wr`=1 starts a read. During the next clock period, `dout` carries the word at `addr`, and `dout_oe` is 1 while `oe_n` is 0.
- R3: A begin write (`rd_wr`=0) registers `addr` and `bw_n`. At the next enabled edge, `din` is sampled and byte lane i (bits 8i+7:8i) is written only where `bw_n[i]`=0.
- R4: Reads and writes may alternate on every clock. A read issued in the cycle right after a write to the same address returns the new bytes merged over the old ones.
- R5: A write whose `bw_n` is 4'b1111 is an abort. No word changes and `dout_oe` stays 0 during its data cycle.
- R6: A begin cycle with any chip select inactive is a deselect. The next period has `dout_oe`=0 and nothing is written.
- R7: When `ld_n`=1, the cycle repeats the operation of the last begin cycle at `burst_addr`. `addr`, the chip selects and `rd_wr` are ignored. A continue after a deselect is itself a deselect.
- R8: `dout_oe` can be 1 only while `oe_n` is 0, and it follows `oe_n` with no clock edge. A read begun with `oe_n`=1 is a dummy read.
- R9: A write or write-continue cycle never drives the bus (`dout_oe`=0).
- R10: An edge with `clk_en_n`=1 changes no state and writes nothing. A read in progress keeps driving the same data, and a write in progress stays undriven with its data still to come.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the cycle |
| ce0_n | input | 1 | Chip select, active low |
| ce1 | input | 1 | Chip select, active high |
| ce2_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low: begin new cycle; high: continue burst |
| rd_wr | input | 1 | High read, low write (begin cycles only) |
| bw_n | input | 4 | Active-low byte write enables, bit i = lane i |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Address for begin cycles |
| burst_addr | input | ADDR_W | Address from the burst generator for continue cycles |
| din | input | DATA_W | Write data, one cycle after the write command |
| dout | output | DATA_W | Read data |
| dout_oe | output | 1 | High when the data bus must be driven |

## Verification
The hardest case to reach is a read that lands on a word whose late data is still in the staging register. In that case a partial byte mask has to be merged over older array contents, and it is easy to get wrong. The bench reaches it by first writing a full word and then issuing a masked write to the same address. The read of that address goes out on the very next clock, while the masked data is being captured. The same address is read again after an idle cycle, which checks the value that was committed to the array. Stalls are placed between a write command and its data edge, with wrong data on `din` during the stall, to show that only the enabled edge samples the bus.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
   typedef enum logic [1:0] {
      OP_DESEL = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
   import lwsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_n,
   input  logic              ce0_n,
   input  logic              ce1,
   input  logic              ce2_n,
   input  logic              ld_n,
   input  logic              rd_wr,
   input  logic [LANES-1:0]  bw_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] burst_addr,
   output op_e               cur_op,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [LANES-1:0]  cur_bw_n
);
   op_e  burst_op;
   op_e  next_op;
   logic sel;

   always_comb begin
      sel = !ce0_n && ce1 && !ce2_n;
      if (!ld_n)
         next_op = sel ? (rd_wr ? OP_READ : OP_WRITE) : OP_DESEL;
      else
         next_op = burst_op;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_op   <= OP_DESEL;
         burst_op <= OP_DESEL;
         cur_addr <= '0;
         cur_bw_n <= '1;
      end else if (!clk_en_n) begin
         cur_op   <= next_op;
         cur_addr <= ld_n ? burst_addr : addr;
         cur_bw_n <= bw_n;
         if (!ld_n)
            burst_op <= next_op;
      end
   end

   // R10: an inhibited edge leaves the command pipeline untouched
   a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> ($stable(cur_op) && $stable(cur_addr) && $stable(burst_op)));

   // R7: a continue cycle repeats the operation of the burst start
   a_r7_cont_inherits: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && ld_n) |=> (cur_op == $past(burst_op)));
endmodule

// File: rtl/lwsram_wstage.sv
module lwsram_wstage
   import lwsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_n,
   input  op_e               cur_op,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [LANES-1:0]  cur_bw_n,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [LANES-1:0]  wr_be,
   output logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int LANE_W = DATA_W / LANES;

   logic              pend_valid;
   logic [ADDR_W-1:0] pend_addr;
   logic [LANES-1:0]  pend_be;
   logic [DATA_W-1:0] pend_data;
   logic              load;
   logic              addr_hit;

   assign load = (cur_op == OP_WRITE) && (cur_bw_n != '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_addr  <= '0;
         pend_be    <= '0;
         pend_data  <= '0;
      end else if (!clk_en_n) begin
         pend_valid <= load;
         if (load) begin
            pend_addr <= cur_addr;
            pend_be   <= ~cur_bw_n;
            pend_data <= din;
         end
      end
   end

   assign wr_en    = !clk_en_n && pend_valid;
   assign wr_addr  = pend_addr;
   assign wr_be    = pend_be;
   assign wr_data  = pend_data;
   assign addr_hit = pend_valid && (pend_addr == cur_addr);

   for (genvar i = 0; i < LANES; i++) begin : g_fwd
      assign rd_data[i*LANE_W +: LANE_W] = (addr_hit && pend_be[i])
         ? pend_data[i*LANE_W +: LANE_W] : arr_rdata[i*LANE_W +: LANE_W];
   end

   // R5: a fully masked write never reaches the staging register
   a_r5_abort_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && cur_op == OP_WRITE && cur_bw_n == '1) |=> !pend_valid);

   // R3: data is taken from the bus on the edge after the command
   a_r3_late_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && load) |=> (pend_valid && pend_data == $past(din)));
endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LANES-1:0]  wr_be,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int LANE_W = DATA_W / LANES;
   localparam int DEPTH  = 1 << ADDR_W;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && wr_be[i])
            mem[wr_addr] <= wr_data[i*LANE_W +: LANE_W];
      end
      assign rd_data[i*LANE_W +: LANE_W] = mem[rd_addr];
   end
endmodule

// File: rtl/lw_burst_sram.sv
module lw_burst_sram
   import lwsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_n,
   input  logic              ce0_n,
   input  logic              ce1,
   input  logic              ce2_n,
   input  logic              ld_n,
   input  logic              rd_wr,
   input  logic [LANES-1:0]  bw_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] burst_addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);
   if (DATA_W % LANES != 0) begin : g_bad_lanes
      $error("DATA_W must split evenly into LANES");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W out of supported range");
   end

   op_e               cur_op;
   logic [ADDR_W-1:0] cur_addr;
   logic [LANES-1:0]  cur_bw_n;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [LANES-1:0]  wr_be;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] arr_rdata;
   logic [DATA_W-1:0] rd_data;
   logic              begin_sel;

   lwsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
      .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
      .ld_n(ld_n), .rd_wr(rd_wr), .bw_n(bw_n),
      .addr(addr), .burst_addr(burst_addr),
      .cur_op(cur_op), .cur_addr(cur_addr), .cur_bw_n(cur_bw_n)
   );

   lwsram_wstage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_wstage (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
      .cur_op(cur_op), .cur_addr(cur_addr), .cur_bw_n(cur_bw_n),
      .din(din), .arr_rdata(arr_rdata),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
      .rd_data(rd_data)
   );

   lwsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_array (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
      .wr_data(wr_data), .rd_addr(cur_addr), .rd_data(arr_rdata)
   );

   assign dout      = rd_data;
   assign dout_oe   = (cur_op == OP_READ) && !oe_n;
   assign begin_sel = !ld_n && !ce0_n && ce1 && !ce2_n;

   // R6: a begin cycle with any select inactive leaves the bus undriven
   a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !ld_n && !(!ce0_n && ce1 && !ce2_n)) |=> !dout_oe);

   // R9: a begin write never drives the bus in its data cycle
   a_r9_write_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && begin_sel && !rd_wr) |=> !dout_oe);

   // R8: the drivers are off whenever output enable is inactive
   a_r8_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_oe);
endmodule

// File: tb/lw_burst_sram_tb.sv
module lw_burst_sram_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en_n = 1'b0;
   logic        ce0_n = 1'b1, ce1 = 1'b0, ce2_n = 1'b1;
   logic        ld_n = 1'b0, rd_wr = 1'b1;
   logic [3:0]  bw_n = 4'hF;
   logic        oe_n = 1'b0;
   logic [5:0]  addr = '0, burst_addr = '0;
   logic [31:0] din = '0;
   logic [31:0] dout;
   logic        dout_oe;

   int checks = 0;
   int failures = 0;

   localparam logic [2:0] SEL = 3'b010; // {ce2_n, ce1, ce0_n}

   always #5 clk = ~clk;

   lw_burst_sram u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
      .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
      .ld_n(ld_n), .rd_wr(rd_wr), .bw_n(bw_n), .oe_n(oe_n),
      .addr(addr), .burst_addr(burst_addr), .din(din),
      .dout(dout), .dout_oe(dout_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock: drive at negedge, step across the edge, return at next negedge
   task automatic cyc(input logic ld, input logic rw, input logic [2:0] ce,
                      input logic [3:0] bw, input logic [5:0] a, input logic [5:0] ba,
                      input logic [31:0] d, input logic stall);
      ld_n = ld; rd_wr = rw; {ce2_n, ce1, ce0_n} = ce;
      bw_n = bw; addr = a; burst_addr = ba; din = d; clk_en_n = stall;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [3:0] bw, input logic [31:0] d);
      cyc(1'b0, 1'b0, SEL, bw, a, 6'd0, d, 1'b0);
   endtask
   task automatic rd(input logic [5:0] a, input logic [31:0] d);
      cyc(1'b0, 1'b1, SEL, 4'hF, a, 6'd0, d, 1'b0);
   endtask
   task automatic nop(input logic [31:0] d);
      cyc(1'b0, 1'b1, 3'b111, 4'hF, 6'd0, 6'd0, d, 1'b0);
   endtask

   task automatic t_reset;
      chk("R1 reset bus undriven", {31'd0, dout_oe}, 32'd0);
      // continue right after reset must behave as a deselect
      cyc(1'b1, 1'b1, SEL, 4'h0, 6'd1, 6'd1, 32'h0, 1'b0);
      chk("R1 continue after reset is deselect", {31'd0, dout_oe}, 32'd0);
   endtask

   task automatic t_alternate;
      wr(6'd5, 4'h0, 32'h0);
      chk("R9 write cycle undriven", {31'd0, dout_oe}, 32'd0);
      rd(6'd5, 32'h11111111);
      chk("R4 read after write same addr", dout, 32'h11111111);
      chk("R2 read drives bus", {31'd0, dout_oe}, 32'd1);
      wr(6'd6, 4'h0, 32'h0);
      rd(6'd6, 32'h22222222);
      chk("R4 alternate second pair", dout, 32'h22222222);
      rd(6'd5, 32'h0);
      chk("R2 read older word", dout, 32'h11111111);
      wr(6'd5, 4'b1010, 32'h0);
      rd(6'd5, 32'hAABBCCDD);
      chk("R4 forwarded byte merge", dout, 32'h11BB11DD);
      nop(32'h0);
      rd(6'd5, 32'h0);
      chk("R3 committed byte merge", dout, 32'h11BB11DD);
   endtask

   task automatic t_abort;
      wr(6'd6, 4'hF, 32'h0);
      nop(32'hDEADBEEF);
      chk("R5 abort data cycle undriven", {31'd0, dout_oe}, 32'd0);
      rd(6'd6, 32'h0);
      chk("R5 abort leaves word", dout, 32'h22222222);
   endtask

   task automatic t_desel;
      wr(6'd7, 4'h0, 32'h0);
      nop(32'h77777777);
      cyc(1'b0, 1'b0, 3'b011, 4'h0, 6'd7, 6'd0, 32'h0, 1'b0);
      cyc(1'b0, 1'b0, 3'b000, 4'h0, 6'd7, 6'd0, 32'h0BAD0001, 1'b0);
      cyc(1'b0, 1'b0, 3'b110, 4'h0, 6'd7, 6'd0, 32'h0BAD0002, 1'b0);
      cyc(1'b0, 1'b1, 3'b011, 4'hF, 6'd7, 6'd0, 32'h0BAD0003, 1'b0);
      chk("R6 deselected read undriven", {31'd0, dout_oe}, 32'd0);
      rd(6'd7, 32'h0BAD0004);
      chk("R6 deselected writes ignored", dout, 32'h77777777);
   endtask

   task automatic t_burst;
      wr(6'd8, 4'h0, 32'h0);
      cyc(1'b1, 1'b1, 3'b111, 4'h0, 6'd30, 6'd9, 32'h88888888, 1'b0);
      chk("R7 write continue undriven", {31'd0, dout_oe}, 32'd0);
      cyc(1'b1, 1'b1, 3'b111, 4'h0, 6'd31, 6'd10, 32'h99999999, 1'b0);
      rd(6'd8, 32'hAAAAAAAA);
      chk("R7 burst write first word", dout, 32'h88888888);
      cyc(1'b1, 1'b0, 3'b111, 4'h0, 6'd5, 6'd9, 32'h0, 1'b0);
      chk("R7 read continue at burst_addr", dout, 32'h99999999);
      chk("R7 read continue drives", {31'd0, dout_oe}, 32'd1);
      cyc(1'b1, 1'b0, 3'b111, 4'h0, 6'd5, 6'd10, 32'h0, 1'b0);
      chk("R7 read continue third word", dout, 32'hAAAAAAAA);
      nop(32'h0);
      cyc(1'b1, 1'b0, SEL, 4'h0, 6'd8, 6'd8, 32'h0, 1'b0);
      chk("R7 continue after deselect undriven", {31'd0, dout_oe}, 32'd0);
      nop(32'h55555555);
      rd(6'd8, 32'h0);
      chk("R7 continue after deselect no write", dout, 32'h88888888);
   endtask

   task automatic t_oe;
      oe_n = 1'b1;
      rd(6'd5, 32'h0);
      chk("R8 dummy read undriven", {31'd0, dout_oe}, 32'd0);
      oe_n = 1'b0;
      #1;
      chk("R8 async enable on", {31'd0, dout_oe}, 32'd1);
      chk("R8 data under async enable", dout, 32'h11BB11DD);
      oe_n = 1'b1;
      #1;
      chk("R8 async enable off", {31'd0, dout_oe}, 32'd0);
      oe_n = 1'b0;
   endtask

   task automatic t_stall;
      rd(6'd6, 32'h0);
      cyc(1'b0, 1'b1, SEL, 4'hF, 6'd5, 6'd0, 32'h0, 1'b1);
      chk("R10 stall holds read data", dout, 32'h22222222);
      chk("R10 stall keeps driving", {31'd0, dout_oe}, 32'd1);
      wr(6'd11, 4'h0, 32'h0);
      cyc(1'b0, 1'b1, SEL, 4'hF, 6'd11, 6'd0, 32'h0BADBAD0, 1'b1);
      chk("R10 stall in write undriven", {31'd0, dout_oe}, 32'd0);
      nop(32'hCAFEF00D);
      rd(6'd11, 32'h0);
      chk("R10 data sampled after stall", dout, 32'hCAFEF00D);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_alternate();
      t_abort();
      t_desel();
      t_burst();
      t_oe();
      t_stall();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule